// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus that a slave has left stuck with SDA held low. A bus controller pulses `start_i` when it has not seen SDA high within its short bus-free wait before an address phase. The sequencer then takes the pins from the normal transfer engine. It signals this on `pin_override_o`, and while that flag is high the pin pull-down enables come from the sequencer alone.

With SDA released, the sequencer clocks SCL for a fixed number of pulses. It then drives a stop condition on the bus. The pattern is built from steps. Each step lasts a fixed number of microsecond ticks, supplied on `us_tick_i` by a shared timebase.

At the end of the last step the block samples SDA. It raises `done_o` for one cycle and releases the pins. `busy_err_o` is set if SDA was still low at that moment, and it stays set until the next start.

Top module: `bus_clear_seq`

## Requirements
- R1: After a synchronous active-low reset, `scl_pull_o`, `sda_pull_o`, `pin_override_o`, `done_o` and `busy_err_o` are all 0.
- R2: A `start_i` pulse while idle sets `pin_override_o` on the next clock edge and clears `busy_err_o`. The sequence begins at step 0.
- R3: Steps 0 to 17 form 9 SCL pulses with SDA released (`sda_pull_o`=0). In even steps SCL is released (`scl_pull_o`=0). In odd steps SCL is pulled low (`scl_pull_o`=1).
- R4: Each step lasts exactly STEP_US (default 5) cycles in which `us_tick_i` is high. A step still shows its own pin levels after STEP_US-1 ticks.
- R5: Steps 18 to 22 form the stop pattern, given here as (`scl_pull_o`,`sda_pull_o`):
  - step 18: (1,0), the idle step.
  - step 19: (1,0).
  - step 20: (1,1).
  - step 21: (0,1).
  - step 22: (0,0).
- R6: On the edge that ends step 22, `done_o` goes to 1 for exactly one cycle. On the same edge `pin_override_o` and both pull enables return to 0.
- R7: On that same edge, `busy_err_o` takes the inverse of `sda_in_i`: it is 1 if SDA was low. It holds that value until the next accepted start.
- R8: A `start_i` pulse while a sequence is running is ignored. The pin pattern continues and the sequence ends at its original time.
- R9: While idle, `us_tick_i` has no effect: the pins stay released and `done_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to start a bus-clear sequence |
| sda_in_i | input | 1 | Synchronised level of the SDA line |
| us_tick_i | input | 1 | One-cycle pulse once per microsecond |
| scl_pull_o | output | 1 | SCL pull-down enable (1 = drive low, 0 = released) |
| sda_pull_o | output | 1 | SDA pull-down enable (1 = drive low, 0 = released) |
| pin_override_o | output | 1 | High while the sequencer owns the pins |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| busy_err_o | output | 1 | SDA was still low at the end of the last sequence |

## Verification
The assertions assume that `sda_in_i` is already synchronised to `clk`. They also assume that `us_tick_i` is a single-cycle pulse, so a step boundary is one clean edge.

The bench drives every tick and every start as a one-cycle pulse at the falling edge. It keeps SDA constant across each sequence. It places any extra start mid-step, where it cannot coincide with a tick. Pin levels are checked at two points in every step: after two ticks, and after STEP_US-1 ticks.

// File: rtl/bcs_pkg.sv
// Package: shared types and constants for the bus-clear sequencer.
// Assumes: nothing; pure declarations.
package bcs_pkg;

    // Number of steps in the stop pattern that follows the SCL pulses.
    localparam int unsigned STOP_STEPS = 5;

    // Pull-down request for the two bus pins (1 = drive the line low).
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pin_drive_t;

endpackage

// File: rtl/bcs_step_timer.sv
// Module: counts microsecond ticks and flags the last tick of each step.
// Assumes: tick_i is a one-cycle pulse; counting happens only while run_i.
module bcs_step_timer #(
    parameter int unsigned STEP_US = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic step_end_o
);
    localparam int unsigned CW = (STEP_US > 1) ? $clog2(STEP_US) : 1;
    localparam logic [CW-1:0] LAST_TICK = CW'(STEP_US - 1);

    logic [CW-1:0] tick_cnt;

    // Purpose: count ticks within the current step, wrapping at step end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            tick_cnt <= '0;
        end else if (tick_i) begin
            tick_cnt <= (tick_cnt == LAST_TICK) ? '0 : tick_cnt + 1'b1;
        end
    end

    assign step_end_o = run_i && tick_i && (tick_cnt == LAST_TICK);

    // R4: the tick counter never passes the step length
    p_tick_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt <= LAST_TICK);

    // R9: no counting while idle
    p_idle_count_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tick_cnt == '0) || run_i);

endmodule

// File: rtl/bcs_pattern.sv
// Module: maps the current step index to the SCL/SDA pull-down requests.
// Assumes: step_i < 2*PULSES + STOP_STEPS while active_i is high.
module bcs_pattern
    import bcs_pkg::*;
#(
    parameter int unsigned PULSES = 9,
    parameter int unsigned IW     = 5
) (
    input  logic          active_i,
    input  logic [IW-1:0] step_i,
    output pin_drive_t    drive_o
);
    localparam logic [IW-1:0] PULSE_STEPS = IW'(2 * PULSES);

    logic [IW-1:0] stop_idx;
    assign stop_idx = step_i - PULSE_STEPS;

    // Purpose: decode the step into pin levels; everything released when idle.
    always_comb begin
        drive_o = '0;
        if (active_i) begin
            if (step_i < PULSE_STEPS) begin
                // high half first, then low half of each pulse
                drive_o.scl_low = step_i[0];
                drive_o.sda_low = 1'b0;
            end else begin
                case (stop_idx)
                    IW'(0):  drive_o = '{scl_low: 1'b1, sda_low: 1'b0};
                    IW'(1):  drive_o = '{scl_low: 1'b1, sda_low: 1'b0};
                    IW'(2):  drive_o = '{scl_low: 1'b1, sda_low: 1'b1};
                    IW'(3):  drive_o = '{scl_low: 1'b0, sda_low: 1'b1};
                    default: drive_o = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/bus_clear_seq.sv
// Module: I2C bus-clear sequencer top. On start it owns the pins, clocks
// SCL PULSES times with SDA released, issues a stop, and samples SDA.
// Assumes: sda_in_i is synchronised to clk; us_tick_i is one cycle wide.
module bus_clear_seq
    import bcs_pkg::*;
#(
    parameter int unsigned PULSES  = 9,
    parameter int unsigned STEP_US = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sda_in_i,
    input  logic us_tick_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic pin_override_o,
    output logic done_o,
    output logic busy_err_o
);
    localparam int unsigned TOTAL = 2 * PULSES + STOP_STEPS;
    localparam int unsigned IW    = $clog2(TOTAL);
    localparam logic [IW-1:0] LAST_STEP   = IW'(TOTAL - 1);
    localparam logic [IW-1:0] PULSE_STEPS = IW'(2 * PULSES);

    logic          running;
    logic [IW-1:0] step_idx;
    logic          step_end;
    pin_drive_t    drive;

    bcs_step_timer #(.STEP_US(STEP_US)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (running),
        .tick_i     (us_tick_i),
        .step_end_o (step_end)
    );

    bcs_pattern #(.PULSES(PULSES), .IW(IW)) i_pattern (
        .active_i (running),
        .step_i   (step_idx),
        .drive_o  (drive)
    );

    // Purpose: accept starts when idle, advance steps, finish and sample SDA.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            step_idx   <= '0;
            done_o     <= 1'b0;
            busy_err_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!running) begin
                if (start_i) begin
                    running    <= 1'b1;
                    step_idx   <= '0;
                    busy_err_o <= 1'b0;
                end
            end else if (step_end) begin
                if (step_idx == LAST_STEP) begin
                    running    <= 1'b0;
                    step_idx   <= '0;
                    done_o     <= 1'b1;
                    busy_err_o <= !sda_in_i;
                end else begin
                    step_idx <= step_idx + 1'b1;
                end
            end
        end
    end

    assign pin_override_o = running;
    assign scl_pull_o     = drive.scl_low;
    assign sda_pull_o     = drive.sda_low;

    // R9: pins are released whenever the sequencer is idle
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_override_o |-> (!scl_pull_o && !sda_pull_o));

    // R3: SDA is never pulled during the clocking pulses
    p_sda_free_pulsing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && step_idx < PULSE_STEPS) |-> !sda_pull_o);

    // R6: done lasts a single cycle and coincides with pin release
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !pin_override_o);

    // R8: a start during a running sequence does not restart it
    p_restart_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_i && !step_end) |=> (running && $stable(step_idx)));

    // R7: the error flag can only rise when the sequence ends
    p_err_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_err_o) |-> done_o);

endmodule

// File: tb/test_bus_clear_seq.sv
module test_bus_clear_seq;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS      = 23;
    localparam int STEP_TICKS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sda_in_i = 1'b1;
    logic us_tick_i = 1'b0;
    logic scl_pull_o, sda_pull_o, pin_override_o, done_o, busy_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_clear_seq i_bus_clear_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .sda_in_i       (sda_in_i),
        .us_tick_i      (us_tick_i),
        .scl_pull_o     (scl_pull_o),
        .sda_pull_o     (sda_pull_o),
        .pin_override_o (pin_override_o),
        .done_o         (done_o),
        .busy_err_o     (busy_err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_scl(input int s);
        if (s < 18) return (s % 2) == 1;
        return s < 21;
    endfunction

    function automatic logic exp_sda(input int s);
        return (s == 20) || (s == 21);
    endfunction

    task automatic do_tick();
        @(negedge clk) us_tick_i = 1'b1;
        @(negedge clk) us_tick_i = 1'b0;
    endtask

    task automatic gap();
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 scl", scl_pull_o, 0);
        check("R1 sda", sda_pull_o, 0);
        check("R1 override", pin_override_o, 0);
        check("R1 done", done_o, 0);
        check("R1 err", busy_err_o, 0);
    endtask

    task automatic test_idle_ticks();
        for (int k = 0; k < 12; k++) begin
            do_tick();
            check("R9 scl", scl_pull_o, 0);
            check("R9 sda", sda_pull_o, 0);
            check("R9 override", pin_override_o, 0);
            check("R9 done", done_o, 0);
        end
    endtask

    // One full sequence; sda_level held for the whole run.
    task automatic run_sequence(input logic sda_level, input bit inject_start);
        sda_in_i = sda_level;
        pulse_start();
        check("R2 override", pin_override_o, 1);
        check("R2 err cleared", busy_err_o, 0);
        for (int s = 0; s < STEPS; s++) begin
            do_tick(); gap(); do_tick();
            check(s < 18 ? "R3 scl" : "R5 scl", scl_pull_o, exp_scl(s));
            check(s < 18 ? "R3 sda" : "R5 sda", sda_pull_o, exp_sda(s));
            if (inject_start && s == 10) pulse_start();
            gap(); do_tick(); gap(); do_tick();
            check("R4 scl held", scl_pull_o, exp_scl(s));
            check("R4 sda held", sda_pull_o, exp_sda(s));
            check("R6 done early", done_o, 0);
            check(inject_start ? "R8 still running" : "R4 still running", pin_override_o, 1);
            gap(); do_tick();
            if (s < STEPS - 1) begin
                gap();
            end else begin
                check("R6 done", done_o, 1);
                check("R6 override off", pin_override_o, 0);
                check("R6 scl off", scl_pull_o, 0);
                check("R6 sda off", sda_pull_o, 0);
                check("R7 err", busy_err_o, !sda_level);
                @(negedge clk);
                check("R6 done one cycle", done_o, 0);
                check("R7 err held", busy_err_o, !sda_level);
            end
        end
        sda_in_i = 1'b1;
        gap();
        check("R7 err held after", busy_err_o, !sda_level);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_idle_ticks();
        run_sequence(1'b1, 1'b0);
        run_sequence(1'b0, 1'b0);
        run_sequence(1'b1, 1'b1);
        run_sequence(1'b0, 1'b1);
        test_idle_ticks();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule